// File: doc/BRIEF.md
# Page Access Permission and Reference/Change Updater

This block sits after a page-table walk has delivered a leaf page entry. It takes that entry with the kind of access being made, the processor's user/supervisor state and an authority mask. From these it decides whether the access may proceed and which permissions are granted. On success it produces the entry with its reference and change bits updated, and it raises a write-back request only when the entry actually changed. On failure it builds the fault report. A refused instruction fetch gets an instruction-side report with the cause in an error code. A refused data access gets a data-side report with a status word, which carries a store flag on writes, and the faulting address.

The result is registered one clock after a valid input, and a one-cycle done pulse marks it. The outputs hold their last result until the next valid input. Moving the memory write and walking the table are left to the neighbouring blocks.

Entry layout used by this block:

| Bits | Meaning |
|------|---------|
| 2:0 | Authority: bit 2 read, bit 1 write, bit 0 execute |
| 3 | Supervisor-only page |
| 5:4 | Attribute field; the value 2'b10 means non-idempotent I/O |
| 7 | Change bit |
| 8 | Reference bit |

The authority mask uses the same bit order as bits 2:0 of the entry. The access codes are 0 for load, 1 for store, 2 for fetch and 3 reserved.

Top module: `pte_perm_update`

## Requirements
- R1: Each valid input produces its result on the outputs one clock later, with `done` high for exactly that one cycle; with no valid input, `done` is low and the other outputs keep their values. After reset all outputs are zero.
- R2: A fetch (code 2) from a page whose attribute bits 5:4 equal 2'b10 is refused with cause bit 28 alone, whatever the authority bits say. The same page does not refuse loads or stores for that reason.
- R3: A supervisor-only page (bit 3 set) accessed in user state grants nothing, so every load, store or fetch to it is refused.
- R4: In user state, or on a supervisor-only page in supervisor state, the granted set equals the entry's authority bits 2:0, and the mask has no effect.
- R5: In supervisor state on a page whose bit 3 is clear, the granted set is the authority bits ANDed with the mask (mask bit 2 read, bit 1 write, bit 0 execute).
- R6: When the access needs a permission that is not granted (load needs read, store needs write, fetch needs execute), the access is refused with cause bit 27.
- R7: On an allowed access the output entry has bit 8 set, and bit 7 is also set when the access is a store. The reported grant drops the write bit for any access other than a store.
- R8: The write-back flag is high only when an allowed access produced an entry that differs from the input entry. A refused access returns the entry unchanged with the flag low.
- R9: A refused fetch raises the instruction fault flag, puts the cause in the error code, and leaves the data status and data address at zero.
- R10: A refused load or store raises the data fault flag, puts the cause in the status word with bit 25 added for stores, and captures the access address. The error code is zero.
- R11: Access code 3 is refused as a data fault with cause bit 21 only, and the entry is returned unchanged.
- R12: Granted permissions are reported as zero on any refused access, and the instruction and data fault flags are never high together.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Input set is valid this cycle |
| pte_in | input | PTE_W | Leaf page entry |
| acc_type | input | 2 | 0 load, 1 store, 2 fetch, 3 reserved |
| user_mode | input | 1 | 1 when the processor is in user state |
| auth_mask | input | 3 | Supervisor authority mask (read, write, execute) |
| access_ea | input | EA_W | Address being accessed |
| done | output | 1 | One-cycle result strobe |
| grant_perm | output | 3 | Granted permissions (read, write, execute) |
| pte_out | output | PTE_W | Entry with reference/change bits updated |
| pte_wb | output | 1 | Entry must be written back |
| isi | output | 1 | Instruction-side fault |
| dsi | output | 1 | Data-side fault |
| isi_code | output | CAUSE_W | Error code of an instruction fault |
| dsi_status | output | CAUSE_W | Status word of a data fault |
| dsi_addr | output | EA_W | Faulting address of a data fault |

## Verification
The assertions assume that reset is applied before the first valid input and that the inputs are stable and known whenever `in_valid` is high. They also assume the fault cause bit positions fit inside CAUSE_W. The bench drives inputs only at the falling clock edge, after reset has been released, and always with defined values. All four access codes are used, including the reserved one. Both privilege states are used, and the attribute and reference/change bits are chosen on purpose so that every path through the decision is reached.

// File: rtl/pteperm_pkg.sv
package pteperm_pkg;

  typedef enum logic [1:0] {
    ACC_LOAD  = 2'd0,
    ACC_STORE = 2'd1,
    ACC_FETCH = 2'd2,
    ACC_RSVD  = 2'd3
  } acc_e;

  // permission vector: [2] read, [1] write, [0] execute
  typedef logic [2:0] perm_t;

  localparam int PB_EXEC  = 0;
  localparam int PB_WRITE = 1;
  localparam int PB_READ  = 2;

  // entry field positions
  localparam int E_PRIV   = 3;
  localparam int E_ATT_LO = 4;
  localparam int E_CHG    = 7;
  localparam int E_REF    = 8;
  localparam int E_LOW_W  = 6;   // bits evaluated for permission
  localparam logic [1:0] ATT_NIIO = 2'b10;

  // cause bit positions
  localparam int C_GUARD  = 28;
  localparam int C_PROT   = 27;
  localparam int C_STORE  = 25;
  localparam int C_BADCFG = 21;

endpackage

// File: rtl/pteperm_eval.sv
module pteperm_eval
  import pteperm_pkg::*;
(
  input  logic [E_LOW_W-1:0] ent_low,
  input  acc_e               acc,
  input  logic               user_mode,
  input  perm_t              mask,
  output perm_t              grant,
  output logic               guard_f,
  output logic               prot_f,
  output logic               cfg_f,
  output logic               deny
);
  perm_t auth;
  perm_t need;
  logic  priv_pg;

  always_comb begin
    auth    = ent_low[2:0];
    priv_pg = ent_low[E_PRIV];
    guard_f = (acc == ACC_FETCH) && (ent_low[E_ATT_LO+1:E_ATT_LO] == ATT_NIIO);
    cfg_f   = (acc == ACC_RSVD);

    if (priv_pg && user_mode)      grant = '0;
    else if (user_mode || priv_pg) grant = auth;
    else                           grant = auth & mask;

    unique case (acc)
      ACC_LOAD:  need = 3'b100;
      ACC_STORE: need = 3'b010;
      ACC_FETCH: need = 3'b001;
      default:   need = 3'b000;
    endcase

    prot_f = !guard_f && !cfg_f && ((need & ~grant) != '0);
    deny   = guard_f | cfg_f | prot_f;
  end
endmodule

// File: rtl/pteperm_rc.sv
module pteperm_rc
  import pteperm_pkg::*;
#(
  parameter int PTE_W = 64
) (
  input  logic [PTE_W-1:0] ent,
  input  acc_e             acc,
  input  perm_t            grant,
  output logic [PTE_W-1:0] ent_upd,
  output logic             changed,
  output perm_t            grant_out
);
  logic is_store;

  always_comb begin
    is_store = (acc == ACC_STORE);
    ent_upd  = ent;
    ent_upd[E_REF] = 1'b1;
    if (is_store) ent_upd[E_CHG] = 1'b1;
    changed   = (ent_upd != ent);
    grant_out = grant;
    if (!is_store) grant_out[PB_WRITE] = 1'b0;
  end
endmodule

// File: rtl/pteperm_fault.sv
module pteperm_fault
  import pteperm_pkg::*;
#(
  parameter int CAUSE_W = 32,
  parameter int EA_W    = 64
) (
  input  logic               deny,
  input  logic               guard_f,
  input  logic               prot_f,
  input  logic               cfg_f,
  input  acc_e               acc,
  input  logic [EA_W-1:0]    ea,
  output logic               is_insn,
  output logic               is_data,
  output logic [CAUSE_W-1:0] code,
  output logic [CAUSE_W-1:0] status,
  output logic [EA_W-1:0]    addr
);
  logic [CAUSE_W-1:0] cause;

  always_comb begin
    cause = '0;
    cause[C_GUARD]  = guard_f;
    cause[C_PROT]   = prot_f;
    cause[C_BADCFG] = cfg_f;

    is_insn = deny && (acc == ACC_FETCH);
    is_data = deny && (acc != ACC_FETCH);

    code   = is_insn ? cause : '0;
    status = '0;
    addr   = '0;
    if (is_data) begin
      status = cause;
      status[C_STORE] = (acc == ACC_STORE);
      addr = ea;
    end
  end
endmodule

// File: rtl/pte_perm_update.sv
module pte_perm_update
  import pteperm_pkg::*;
#(
  parameter int PTE_W   = 64,
  parameter int EA_W    = 64,
  parameter int CAUSE_W = 32
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               in_valid,
  input  logic [PTE_W-1:0]   pte_in,
  input  logic [1:0]         acc_type,
  input  logic               user_mode,
  input  logic [2:0]         auth_mask,
  input  logic [EA_W-1:0]    access_ea,
  output logic               done,
  output logic [2:0]         grant_perm,
  output logic [PTE_W-1:0]   pte_out,
  output logic               pte_wb,
  output logic               isi,
  output logic               dsi,
  output logic [CAUSE_W-1:0] isi_code,
  output logic [CAUSE_W-1:0] dsi_status,
  output logic [EA_W-1:0]    dsi_addr
);
  acc_e               acc;
  perm_t              grant_raw, grant_rc;
  logic               guard_f, prot_f, cfg_f, deny;
  logic [PTE_W-1:0]   ent_upd;
  logic               changed;
  logic               f_insn, f_data;
  logic [CAUSE_W-1:0] f_code, f_status;
  logic [EA_W-1:0]    f_addr;

  assign acc = acc_e'(acc_type);

  pteperm_eval u_eval (
    .ent_low   (pte_in[E_LOW_W-1:0]),
    .acc       (acc),
    .user_mode (user_mode),
    .mask      (auth_mask),
    .grant     (grant_raw),
    .guard_f   (guard_f),
    .prot_f    (prot_f),
    .cfg_f     (cfg_f),
    .deny      (deny)
  );

  pteperm_rc #(.PTE_W(PTE_W)) u_rc (
    .ent       (pte_in),
    .acc       (acc),
    .grant     (grant_raw),
    .ent_upd   (ent_upd),
    .changed   (changed),
    .grant_out (grant_rc)
  );

  pteperm_fault #(.CAUSE_W(CAUSE_W), .EA_W(EA_W)) u_fault (
    .deny    (deny),
    .guard_f (guard_f),
    .prot_f  (prot_f),
    .cfg_f   (cfg_f),
    .acc     (acc),
    .ea      (access_ea),
    .is_insn (f_insn),
    .is_data (f_data),
    .code    (f_code),
    .status  (f_status),
    .addr    (f_addr)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      done       <= 1'b0;
      grant_perm <= '0;
      pte_out    <= '0;
      pte_wb     <= 1'b0;
      isi        <= 1'b0;
      dsi        <= 1'b0;
      isi_code   <= '0;
      dsi_status <= '0;
      dsi_addr   <= '0;
    end else begin
      done <= in_valid;
      if (in_valid) begin
        grant_perm <= deny ? perm_t'(0) : grant_rc;
        pte_out    <= deny ? pte_in : ent_upd;
        pte_wb     <= !deny && changed;
        isi        <= f_insn;
        dsi        <= f_data;
        isi_code   <= f_code;
        dsi_status <= f_status;
        dsi_addr   <= f_addr;
      end
    end
  end
endmodule

// File: rtl/pteperm_chk.sv
module pteperm_chk #(
  parameter int PTE_W   = 64,
  parameter int EA_W    = 64,
  parameter int CAUSE_W = 32
) (
  input logic               clk,
  input logic               rst,
  input logic               in_valid,
  input logic [PTE_W-1:0]   pte_in,
  input logic [1:0]         acc_type,
  input logic               user_mode,
  input logic [2:0]         auth_mask,
  input logic [EA_W-1:0]    access_ea,
  input logic               done,
  input logic [2:0]         grant_perm,
  input logic [PTE_W-1:0]   pte_out,
  input logic               pte_wb,
  input logic               isi,
  input logic               dsi,
  input logic [CAUSE_W-1:0] isi_code,
  input logic [CAUSE_W-1:0] dsi_status,
  input logic [EA_W-1:0]    dsi_addr
);
  // R1
  done_follows_chk: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> done);
  // R1
  done_idle_chk: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> !done);
  // R12
  fault_excl_chk: assert property (@(posedge clk) disable iff (rst)
    !(isi && dsi));
  // R8
  wb_no_fault_chk: assert property (@(posedge clk) disable iff (rst)
    (done && pte_wb) |-> (!isi && !dsi));
  // R7
  ref_set_chk: assert property (@(posedge clk) disable iff (rst)
    (done && !isi && !dsi) |-> pte_out[8]);
  // R7
  no_write_grant_chk: assert property (@(posedge clk) disable iff (rst)
    (in_valid && acc_type != 2'd1) |=> !grant_perm[1]);
  // R9
  isi_fetch_only_chk: assert property (@(posedge clk) disable iff (rst)
    (in_valid && acc_type != 2'd2) |=> !isi);
  // R10
  store_flag_chk: assert property (@(posedge clk) disable iff (rst)
    (in_valid && acc_type == 2'd1) |=> (!dsi || dsi_status[25]));
  // R11
  rsvd_data_fault_chk: assert property (@(posedge clk) disable iff (rst)
    (in_valid && acc_type == 2'd3) |=> (dsi && dsi_status[21] && !pte_wb));
  // R12
  deny_no_grant_chk: assert property (@(posedge clk) disable iff (rst)
    (done && (isi || dsi)) |-> (grant_perm == 3'b000));
  // R10
  dsi_addr_chk: assert property (@(posedge clk) disable iff (rst)
    (done && dsi) |-> (dsi_addr == $past(access_ea)));
endmodule

bind pte_perm_update pteperm_chk #(
  .PTE_W(PTE_W), .EA_W(EA_W), .CAUSE_W(CAUSE_W)
) u_chk (.*);

// File: tb/sim_pte_perm_update.sv
module sim_pte_perm_update;
  localparam int CLK_PERIOD = 10;
  localparam int PTE_W = 64, EA_W = 64, CAUSE_W = 32;

  logic clk = 0, rst = 1, in_valid = 0, user_mode = 0;
  logic [PTE_W-1:0] pte_in = '0;
  logic [1:0] acc_type = '0;
  logic [2:0] auth_mask = '0;
  logic [EA_W-1:0] access_ea = '0;
  logic done, pte_wb, isi, dsi;
  logic [2:0] grant_perm;
  logic [PTE_W-1:0] pte_out;
  logic [CAUSE_W-1:0] isi_code, dsi_status;
  logic [EA_W-1:0] dsi_addr;

  int checks = 0, errors = 0;
  bit finished = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  pte_perm_update #(.PTE_W(PTE_W), .EA_W(EA_W), .CAUSE_W(CAUSE_W)) u0 (.*);

  // expected outputs
  logic e_done, e_wb, e_isi, e_dsi;
  logic [2:0] e_perm;
  logic [63:0] e_pte, e_addr;
  logic [31:0] e_code, e_stat;
  string e_tag;

  typedef struct {
    logic [63:0] pte; logic [1:0] acc; logic usr; logic [2:0] msk;
    logic [63:0] ea; logic vld; string tag;
  } stim_t;
  stim_t q[$];

  task automatic chk(string tag, string fld, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", tag, fld, act, exp);
    end
  endtask

  task automatic compare_all();
    chk(e_done ? e_tag : "R1", "done", 64'(done), 64'(e_done));
    chk(e_tag, "grant", 64'(grant_perm), 64'(e_perm));
    chk(e_tag, "pte_out", pte_out, e_pte);
    chk(e_tag, "wb", 64'(pte_wb), 64'(e_wb));
    chk(e_tag, "isi", 64'(isi), 64'(e_isi));
    chk(e_tag, "dsi", 64'(dsi), 64'(e_dsi));
    chk(e_tag, "code", 64'(isi_code), 64'(e_code));
    chk(e_tag, "status", 64'(dsi_status), 64'(e_stat));
    chk(e_tag, "addr", dsi_addr, e_addr);
  endtask

  // behavioural reference of the requirements
  task automatic model(stim_t s);
    logic [2:0] g, need;
    logic [31:0] cause;
    bit refuse;
    e_done = s.vld;
    if (!s.vld) return;
    e_tag = s.tag;
    cause = 0; refuse = 0; g = 0;
    if (s.acc == 2 && s.pte[5:4] == 2'b10) begin refuse = 1; cause = 32'h1000_0000; end
    else if (s.acc == 3) begin refuse = 1; cause = 32'h0020_0000; end
    else begin
      if (s.pte[3] && s.usr) g = 0;
      else if (s.usr || s.pte[3]) g = s.pte[2:0];
      else g = s.pte[2:0] & s.msk;
      need = (s.acc == 0) ? 3'b100 : (s.acc == 1) ? 3'b010 : 3'b001;
      if ((need & ~g) != 0) begin refuse = 1; cause = 32'h0800_0000; end
    end
    e_isi = 0; e_dsi = 0; e_code = 0; e_stat = 0; e_addr = 0;
    if (refuse) begin
      e_perm = 0; e_pte = s.pte; e_wb = 0;
      if (s.acc == 2) begin e_isi = 1; e_code = cause; end
      else begin
        e_dsi = 1;
        e_stat = cause | ((s.acc == 1) ? 32'h0200_0000 : 32'h0);
        e_addr = s.ea;
      end
    end else begin
      e_pte = s.pte | 64'h100 | ((s.acc == 1) ? 64'h80 : 64'h0);
      e_wb = (e_pte != s.pte);
      e_perm = (s.acc == 1) ? g : (g & 3'b101);
    end
  endtask

  function automatic stim_t mk(logic [63:0] p, logic [1:0] a, logic u,
                               logic [2:0] m, logic [63:0] ea, string t);
    stim_t s;
    s.pte = p; s.acc = a; s.usr = u; s.msk = m; s.ea = ea; s.vld = 1; s.tag = t;
    return s;
  endfunction

  function automatic stim_t idle();
    stim_t s;
    s.pte = 0; s.acc = 0; s.usr = 0; s.msk = 0; s.ea = 0; s.vld = 0; s.tag = "R1";
    return s;
  endfunction

  initial begin
    // R2 guarded fetch, and same page for load
    q.push_back(mk(64'h27, 2, 0, 3'b111, 64'hA000, "R2"));
    q.push_back(mk(64'h27, 0, 0, 3'b111, 64'hA008, "R2"));
    q.push_back(idle());
    // R3 supervisor-only page in user state
    q.push_back(mk(64'h0F, 0, 1, 3'b111, 64'hB000, "R3"));
    q.push_back(mk(64'h0F, 2, 1, 3'b111, 64'hB010, "R3"));
    // R4 user state / supervisor-only page: mask ignored
    q.push_back(mk(64'h04, 0, 1, 3'b000, 64'hC000, "R4"));
    q.push_back(mk(64'h0B, 2, 0, 3'b000, 64'hC010, "R4"));
    q.push_back(idle());
    // R5 supervisor on normal page: masked
    q.push_back(mk(64'h07, 1, 0, 3'b010, 64'hD000, "R5"));
    q.push_back(mk(64'h07, 0, 0, 3'b010, 64'hD008, "R5"));
    q.push_back(mk(64'h07, 2, 0, 3'b101, 64'hD010, "R5"));
    // R6 missing exec / write
    q.push_back(mk(64'h06, 2, 1, 3'b111, 64'hE000, "R6"));
    q.push_back(mk(64'h05, 1, 1, 3'b111, 64'hE008, "R6"));
    // R7 store sets both bits, load hides write
    q.push_back(mk(64'h02, 1, 1, 3'b000, 64'hF000, "R7"));
    q.push_back(mk(64'h06, 0, 1, 3'b000, 64'hF008, "R7"));
    // R8 nothing to change
    q.push_back(mk(64'h104, 0, 1, 3'b000, 64'h1000, "R8"));
    q.push_back(mk(64'h182, 1, 1, 3'b000, 64'h1008, "R8"));
    q.push_back(idle());
    // R9 / R10 fault reports
    q.push_back(mk(64'h06, 2, 0, 3'b111, 64'h2000, "R9"));
    q.push_back(mk(64'h05, 1, 1, 3'b000, 64'h2468, "R10"));
    q.push_back(mk(64'h03, 0, 1, 3'b000, 64'h2470, "R10"));
    // R11 reserved code
    q.push_back(mk(64'h1FF, 3, 0, 3'b111, 64'h3000, "R11"));
    q.push_back(idle());
    for (int i = 0; i < 300; i++) begin
      logic [63:0] p;
      p = {$urandom, $urandom};
      if (($urandom % 5) == 0) q.push_back(idle());
      else q.push_back(mk(p, 2'($urandom), 1'($urandom), 3'($urandom),
                          {$urandom, $urandom}, "R12"));
    end
  end

  initial begin
    stim_t s;
    e_done = 0; e_perm = 0; e_pte = 0; e_wb = 0; e_isi = 0; e_dsi = 0;
    e_code = 0; e_stat = 0; e_addr = 0; e_tag = "R1";
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    compare_all(); // reset state
    #1;
    while (q.size() > 0) begin
      s = q.pop_front();
      model(s);
      in_valid = s.vld; pte_in = s.pte; acc_type = s.acc;
      user_mode = s.usr; auth_mask = s.msk; access_ea = s.ea;
      @(negedge clk);
      compare_all();
    end
    in_valid = 0;
    e_done = 0;
    @(negedge clk);
    compare_all();
    if (!finished) begin
      finished = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      checks++; errors++;
      $display("FAIL R1 watchdog actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule